// File: doc/BRIEF.md
# Power-Fail Chip-Enable Gate

This block sits between a host's active-low memory select and a battery-backed static RAM. While the supply is in tolerance, the select passes straight through. When an external comparator lowers its digital power-good flag, the block deselects the memory so that nothing can write to it while the supply is failing. A write that is already under way when the flag drops may finish. That grace period ends either when the host releases its select or when a write-protect timeout expires, whichever comes first.

Once power-good returns, the memory stays deselected for a recovery hold of fixed length, so that the host processor can settle before it regains access. A power dip during that hold restarts the hold. Both time limits are counted in clock cycles and set by parameters. The defaults correspond to roughly 100 µs of write-protect time and 80 ms of recovery at 250 MHz. Both parameters must be at least 2. If power returns while a write is still draining, the write is not cut short; the recovery hold starts in the first cycle after the drain ends.

Top module: `pfg_ce_gate`

## Requirements
- R1: The select encoding is 0 = memory selected and 1 = deselected. While the block is in normal operation with `pwr_ok` high, `mem_ce_n` equals `host_ce_n` in the same cycle, with no register in the path.
- R2: Take a cycle in which `pwr_ok` is low and `mem_ce_n` was high in the previous cycle. In that cycle `mem_ce_n` is 1 whatever `host_ce_n` is, and this includes a host select that falls in the same cycle as `pwr_ok`.
- R3: Suppose `mem_ce_n` was 0 in the cycle before `pwr_ok` fell. Then `mem_ce_n` keeps following `host_ce_n` until the host first drives 1. From that cycle on, `mem_ce_n` stays 1 until a recovery hold completes.
- R4: Count the cycle in which `pwr_ok` falls as cycle 0. `mem_ce_n` can be 0 only in cycles 0 to `WP_TICKS`-1, and it is 1 from cycle `WP_TICKS` on, even if `host_ce_n` is still 0.
- R5: In the protected state, the first cycle with `pwr_ok` high starts the hold. `mem_ce_n` stays 1 for `REC_TICKS` consecutive cycles from that cycle, whatever `host_ce_n` is.
- R6: If `pwr_ok` goes low at any point in the recovery hold, `mem_ce_n` stays 1 and the next rise of `pwr_ok` starts a full new hold of `REC_TICKS` cycles.
- R7: If `host_ce_n` is 0 when the hold ends, `mem_ce_n` becomes 0 in cycle `REC_TICKS`, counted from the first high cycle of `pwr_ok`.
- R8: `rst` is synchronous and active high. From the first clock edge with `rst` high, the block is protected with `mem_ce_n` at 1. After `rst` is released with `pwr_ok` high, it still runs a full recovery hold before any select passes through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing is counted in its cycles |
| rst | input | 1 | Synchronous reset, active high |
| host_ce_n | input | 1 | Host memory select, active low |
| pwr_ok | input | 1 | Supply above the deselect threshold (1 = valid) |
| mem_ce_n | output | 1 | Conditioned select to the memory, active low |

## Verification
The hardest case to reach is the write-protect timeout. It needs the host to hold its select low through the whole outage, starting with a select that was already low in the cycle before power-good fell. Reaching a timeout at the default length would also take tens of thousands of cycles. The bench therefore builds the block with short tick limits and keeps the select low from before the drop until past the limit. The dip-during-hold case is reached by raising power-good, letting the hold run part way, lowering power-good for a single cycle, and then timing a complete new hold.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    // Select levels on both the host side and the memory side
    localparam logic CE_SEL  = 1'b0;
    localparam logic CE_IDLE = 1'b1;

    // Operating states of the gate
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,   // supply valid, select passes through
        ST_DRAIN = 2'd1,   // supply failed, open access allowed to finish
        ST_PROT  = 2'd2,   // supply failed, memory deselected
        ST_RECOV = 2'd3    // supply back, hold running
    } gate_st_e;

    // Controls for the two cycle timers
    typedef struct packed {
        logic wp_start;
        logic wp_step;
        logic rec_start;
        logic rec_step;
    } tmr_ctl_t;

    // Width of a counter that must reach the value lim
    function automatic int unsigned tick_bits(input int unsigned lim);
        return (lim < 2) ? 1 : $clog2(lim + 1);
    endfunction

    // Conditioned select for a given state and inputs
    function automatic logic cond_ce(input gate_st_e st,
                                     input logic     host_n,
                                     input logic     prev_n,
                                     input logic     ok);
        logic r;
        case (st)
            ST_RUN:   r = ok ? host_n : (host_n | prev_n);
            ST_DRAIN: r = host_n;
            default:  r = CE_IDLE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pfg_tick_ctr.sv
module pfg_tick_ctr
    import pfg_pkg::*;
#(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic step,
    output logic hit
);

    localparam int unsigned W    = tick_bits(LIMIT);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);
    localparam logic [W-1:0] TOP  = W'(LIMIT);

    logic [W-1:0] cnt_q;

    // start marks the first elapsed cycle; step counts each later one
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= ONE;
        end else if (step && (cnt_q != TOP)) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign hit = (cnt_q == LAST);

endmodule

// File: rtl/pfg_ctrl.sv
module pfg_ctrl
    import pfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pwr_ok,
    input  logic     host_ce_n,
    input  logic     mem_ce_n,
    input  logic     wp_hit,
    input  logic     rec_hit,
    output gate_st_e st_q,
    output tmr_ctl_t ctl
);

    gate_st_e st_d;

    always_comb begin
        st_d = st_q;
        ctl  = '0;
        case (st_q)
            ST_RUN: begin
                if (!pwr_ok) begin
                    // an access survives the drop only if the memory is selected now
                    if (mem_ce_n == CE_SEL) begin
                        st_d         = ST_DRAIN;
                        ctl.wp_start = 1'b1;
                    end else begin
                        st_d = ST_PROT;
                    end
                end
            end
            ST_DRAIN: begin
                ctl.wp_step = 1'b1;
                if ((host_ce_n == CE_IDLE) || wp_hit) begin
                    st_d = ST_PROT;
                end
            end
            ST_PROT: begin
                if (pwr_ok) begin
                    st_d          = ST_RECOV;
                    ctl.rec_start = 1'b1;
                end
            end
            ST_RECOV: begin
                ctl.rec_step = 1'b1;
                if (!pwr_ok) begin
                    st_d = ST_PROT;
                end else if (rec_hit) begin
                    st_d = ST_RUN;
                end
            end
            default: st_d = ST_PROT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_PROT;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pfg_gate.sv
module pfg_gate
    import pfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  gate_st_e st_q,
    input  logic     host_ce_n,
    input  logic     pwr_ok,
    output logic     mem_ce_n
);

    // memory select level of the previous cycle: marks an open access
    logic prev_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_n_q <= CE_IDLE;
        end else begin
            prev_n_q <= mem_ce_n;
        end
    end

    assign mem_ce_n = cond_ce(st_q, host_ce_n, prev_n_q, pwr_ok);

endmodule

// File: rtl/pfg_ce_gate.sv
module pfg_ce_gate
    import pfg_pkg::*;
#(
    parameter int unsigned WP_TICKS  = 25000,
    parameter int unsigned REC_TICKS = 20000000
) (
    input  logic clk,
    input  logic rst,
    input  logic host_ce_n,
    input  logic pwr_ok,
    output logic mem_ce_n
);

    gate_st_e st_q;
    tmr_ctl_t ctl;
    logic     wp_hit;
    logic     rec_hit;

    pfg_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .pwr_ok    (pwr_ok),
        .host_ce_n (host_ce_n),
        .mem_ce_n  (mem_ce_n),
        .wp_hit    (wp_hit),
        .rec_hit   (rec_hit),
        .st_q      (st_q),
        .ctl       (ctl)
    );

    pfg_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .st_q      (st_q),
        .host_ce_n (host_ce_n),
        .pwr_ok    (pwr_ok),
        .mem_ce_n  (mem_ce_n)
    );

    // write-protect timer: cycles elapsed since the drop with an open access
    pfg_tick_ctr #(.LIMIT(WP_TICKS)) u_wp_ctr (
        .clk   (clk),
        .rst   (rst),
        .start (ctl.wp_start),
        .step  (ctl.wp_step),
        .hit   (wp_hit)
    );

    // recovery timer: cycles elapsed since power-good returned
    pfg_tick_ctr #(.LIMIT(REC_TICKS)) u_rec_ctr (
        .clk   (clk),
        .rst   (rst),
        .start (ctl.rec_start),
        .step  (ctl.rec_step),
        .hit   (rec_hit)
    );

endmodule

// File: rtl/pfg_ce_gate_chk.sv
module pfg_ce_gate_chk
    import pfg_pkg::*;
#(
    parameter int unsigned WP_TICKS  = 25000,
    parameter int unsigned REC_TICKS = 20000000
) (
    input logic     clk,
    input logic     rst,
    input logic     host_ce_n,
    input logic     pwr_ok,
    input logic     mem_ce_n,
    input gate_st_e st_q
);

    localparam int unsigned WW = tick_bits(WP_TICKS);
    localparam int unsigned RW = tick_bits(REC_TICKS);
    localparam logic [WW-1:0] W_TOP = WW'(WP_TICKS);
    localparam logic [RW-1:0] R_TOP = RW'(REC_TICKS);

    logic [WW-1:0] low_run;  // earlier consecutive cycles selected with power bad
    logic [RW-1:0] ok_run;   // earlier consecutive cycles with power good

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run <= '0;
            ok_run  <= '0;
        end else begin
            if (!pwr_ok && !mem_ce_n) begin
                if (low_run != W_TOP) low_run <= low_run + WW'(1);
            end else begin
                low_run <= '0;
            end
            if (pwr_ok) begin
                if (ok_run != R_TOP) ok_run <= ok_run + RW'(1);
            end else begin
                ok_run <= '0;
            end
        end
    end

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && pwr_ok) |-> (mem_ce_n == host_ce_n));                // R1

    AST_NO_NEW_SELECT: assert property (@(posedge clk) disable iff (rst)
        (!pwr_ok && $past(mem_ce_n)) |-> mem_ce_n);                              // R2

    AST_STAYS_OFF: assert property (@(posedge clk) disable iff (rst)
        (!pwr_ok && $rose(mem_ce_n)) |=> mem_ce_n);                              // R3

    AST_WP_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (!pwr_ok && !mem_ce_n) |-> (low_run < W_TOP));                           // R4

    AST_HOLD_AFTER_RETURN: assert property (@(posedge clk) disable iff (rst)
        (pwr_ok && (ok_run < R_TOP) && $past(mem_ce_n)) |-> mem_ce_n);           // R5

endmodule

bind pfg_ce_gate pfg_ce_gate_chk #(
    .WP_TICKS  (WP_TICKS),
    .REC_TICKS (REC_TICKS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .host_ce_n (host_ce_n),
    .pwr_ok    (pwr_ok),
    .mem_ce_n  (mem_ce_n),
    .st_q      (st_q)
);

// File: tb/sim_pfg_ce_gate.sv
`timescale 1ns/1ps
module sim_pfg_ce_gate;

    localparam int WP  = 8;
    localparam int REC = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_ce_n = 1'b1;
    logic pwr_ok = 1'b1;
    logic mem_ce_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pfg_ce_gate #(.WP_TICKS(WP), .REC_TICKS(REC)) u0 (
        .clk       (clk),
        .rst       (rst),
        .host_ce_n (host_ce_n),
        .pwr_ok    (pwr_ok),
        .mem_ce_n  (mem_ce_n)
    );

    // One clock cycle: drive just after the edge, compare mid-cycle
    task automatic cyc(input logic h, input logic p, input logic exp, input string tag);
        host_ce_n = h;
        pwr_ok    = p;
        @(negedge clk);
        n_chk++;
        if (mem_ce_n !== exp) begin
            n_fail++;
            $display("FAIL %s: mem_ce_n=%b expected %b at %0t", tag, mem_ce_n, exp, $time);
        end
        @(posedge clk);
        #1;
    endtask

    // From the protected state: full hold, then the select passes again
    task automatic recover_seq(input string who);
        for (int i = 0; i < REC; i++) cyc(1'b0, 1'b1, 1'b1, {"R5 hold cycle (", who, ")"});
        cyc(1'b0, 1'b1, 1'b0, {"R7 first cycle after hold (", who, ")"});
        cyc(1'b1, 1'b1, 1'b1, {"R1 follows after hold (", who, ")"});
    endtask

    task automatic t_reset();
        rst = 1'b1;
        host_ce_n = 1'b0;
        pwr_ok = 1'b1;
        @(posedge clk);
        #1;
        cyc(1'b0, 1'b1, 1'b1, "R8 protected in reset");
        cyc(1'b0, 1'b1, 1'b1, "R8 protected in reset");
        rst = 1'b0;
        recover_seq("R8 after reset");
        // synchronous reset from normal operation
        cyc(1'b0, 1'b1, 1'b0, "R1 select passes");
        rst = 1'b1;
        cyc(1'b0, 1'b1, 1'b0, "R8 reset acts at the edge");
        cyc(1'b0, 1'b1, 1'b1, "R8 protected after reset edge");
        rst = 1'b0;
        recover_seq("R8 second reset");
    endtask

    task automatic t_follow();
        cyc(1'b1, 1'b1, 1'b1, "R1 idle");
        cyc(1'b0, 1'b1, 1'b0, "R1 select");
        cyc(1'b0, 1'b1, 1'b0, "R1 select held");
        cyc(1'b1, 1'b1, 1'b1, "R1 release");
        cyc(1'b0, 1'b1, 1'b0, "R1 select again");
        cyc(1'b1, 1'b1, 1'b1, "R1 release again");
    endtask

    task automatic t_drop_idle();
        cyc(1'b0, 1'b0, 1'b1, "R2 select in drop cycle blocked");
        cyc(1'b0, 1'b0, 1'b1, "R2 blocked while power bad");
        cyc(1'b1, 1'b0, 1'b1, "R2 blocked while power bad");
        cyc(1'b0, 1'b0, 1'b1, "R2 blocked while power bad");
        recover_seq("R2");
    endtask

    task automatic t_drain_finish();
        cyc(1'b0, 1'b1, 1'b0, "R1 access open");
        cyc(1'b0, 1'b0, 1'b0, "R3 access continues at drop");
        cyc(1'b0, 1'b0, 1'b0, "R3 access continues");
        cyc(1'b0, 1'b0, 1'b0, "R3 access continues");
        cyc(1'b1, 1'b0, 1'b1, "R3 host releases");
        cyc(1'b0, 1'b0, 1'b1, "R3 stays deselected");
        cyc(1'b0, 1'b0, 1'b1, "R3 stays deselected");
        recover_seq("R3");
    endtask

    task automatic t_drain_timeout();
        cyc(1'b0, 1'b1, 1'b0, "R1 access open");
        for (int k = 0; k < WP; k++) cyc(1'b0, 1'b0, 1'b0, "R4 within write-protect time");
        for (int k = 0; k < 4; k++) cyc(1'b0, 1'b0, 1'b1, "R4 forced off after timeout");
        recover_seq("R4");
    endtask

    task automatic t_dip_in_hold();
        cyc(1'b0, 1'b0, 1'b1, "R6 protected");
        for (int i = 0; i < 10; i++) cyc(1'b0, 1'b1, 1'b1, "R6 partial hold");
        cyc(1'b0, 1'b0, 1'b1, "R6 dip during hold");
        recover_seq("R6 restarted hold");
    endtask

    initial begin
        t_reset();
        t_follow();
        t_drop_idle();
        t_follow();
        t_drain_finish();
        t_drain_timeout();
        t_dip_in_hold();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run state=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule